// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated power domain between powered and unpowered states by stepping its control pins through a fixed, timed order. It drives an isolation enable, a power-switch-off control, a set of 32-bit memory power-down banks (two or three, set by a parameter), an extra group of eight single-bit memory power-down controls, a domain reset and two clock enables. All waits count pulses of a one-microsecond tick input, not clock cycles.

Software asks for a transition with a level request (`req_i`, with `req_on_i` choosing the direction). The sequencer accepts it only while idle and answers with a one-cycle acknowledge. A request for the state the domain is already in is acknowledged and does nothing else, so a shutdown request made while the domain is off is harmless. `busy_o` stays high while a sequence runs, `done_o` pulses for one cycle on its last step and `status_off_o` reports the power-switch state.

State machine (`seq_state_e`): `ST_IDLE`; going down `ST_DN_ISO` (isolation set, guard wait) → `ST_DN_MEM` (one memory step per wait) → `ST_DN_SETTLE` (guard wait) → `ST_DN_SWITCH` (switch off, long wait) → `ST_DN_CLKB` (first clock already dropped, drop second) → `ST_IDLE`; going up `ST_UP_SWITCH` (switch on, guard wait) → `ST_UP_MEM` → `ST_UP_SETTLE` → `ST_UP_ISO` (reset already asserted, release isolation) → `ST_UP_RST` (release reset) → `ST_UP_CLKA` (first clock on) → `ST_UP_CLKB` (second clock on) → `ST_IDLE`. From `ST_IDLE` a request goes to `ST_DN_ISO` or `ST_UP_SWITCH`, or stays in `ST_IDLE` when redundant. Each wait state leaves when the tick timer expires; `ST_DN_MEM`/`ST_UP_MEM` loop on themselves until the last step.

Top module: `pwr_gate_seq`

## Requirements
- R1: Reset loads the domain state from `init_on_i`: if 1, isolation, switch-off, reset and all power-down bits are 0 and both clock enables are 1; if 0, isolation, switch-off and all power-down bits are 1, reset and both clock enables are 0. The sequencer is idle.
- R2: Power-down order: isolation set at acceptance; GUARD_TICKS later the first memory step; after the last step's wait plus GUARD_TICKS the switch-off bit rises; SWITCH_TICKS later the first clock enable falls and one cycle after that the second.
- R3: Memory steps: step k for k < 16·NUM_BANKS sets (down) or clears (up) bits 2k+1:2k of `mem_pd_o` (bank b is bits 32b+31:32b), from bit 0 upward; step 16·NUM_BANKS+j then changes `aux_pd_o[j]`, j = 0..7. Each step is followed by a STEP_TICKS wait; no clock edge changes more than two power-down bits. 1 means powered down.
- R4: Power-up order: switch-off cleared at acceptance; GUARD_TICKS later the first memory clear in the same step order; after the last step's wait plus GUARD_TICKS the domain reset rises; on the next cycle isolation falls; on the next reset falls.
- R5: Isolation is 1 whenever the switch-off bit is 1.
- R6: A clock enable rises only while isolation and reset are 0; the second clock enable rises only when the first is already 1, one cycle after it.
- R7: `status_off_o` is 1 exactly when the switch-off bit is 1.
- R8: A request is accepted only in `ST_IDLE`, with a one-cycle `ack_o`; requests while busy get no acknowledge and do not change the running sequence.
- R9: A request for the current state (`req_on_i`=1 while on, 0 while off) is acknowledged, starts no sequence, leaves all outputs unchanged and gives no `done_o`.
- R10: `busy_o` is 1 from the cycle after acceptance until the final step, which is marked by a one-cycle `done_o` with `busy_o` already 0.
- R11: Every wait counts tick pulses: the tick count between an action and the next action is the wait length (or one more).
- R12: With NUM_BANKS = 3 the third bank is stepped after the second and before the single-bit group, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| init_on_i | input | 1 | Domain state to assume at reset (1 = powered) |
| req_i | input | 1 | Transition request, held until acknowledged |
| req_on_i | input | 1 | Requested state (1 = power on, 0 = power off) |
| ack_o | output | 1 | One-cycle request acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on the final step |
| status_off_o | output | 1 | Domain switched off |
| iso_o | output | 1 | Isolation enable (1 = isolated) |
| sw_off_o | output | 1 | Power-switch control (1 = off) |
| dom_rst_o | output | 1 | Domain reset (1 = in reset) |
| clk_en_a_o | output | 1 | First clock enable |
| clk_en_b_o | output | 1 | Second clock enable |
| mem_pd_o | output | 32·NUM_BANKS | Memory bank power-down bits |
| aux_pd_o | output | 8 | Single-bit memory power-down group |

## Verification
The assertions assume `rst_ni` is held low for at least one clock edge before use and that `req_i` stays a level held until `ack_o`, so acknowledge is only ever judged against the idle state. They also assume `tick_i` is a one-cycle pulse never present on consecutive cycles, which the tick-spacing bound relies on. The bench drives the tick every third clock, releases the request on the cycle it sees the acknowledge, and injects extra requests only while a sequence is visibly running, so every accepted transition starts from a settled domain.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_MEM,
        ST_DN_SETTLE,
        ST_DN_SWITCH,
        ST_DN_CLKB,
        ST_UP_SWITCH,
        ST_UP_MEM,
        ST_UP_SETTLE,
        ST_UP_ISO,
        ST_UP_RST,
        ST_UP_CLKA,
        ST_UP_CLKB
    } seq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_gate_timer.sv
module pwr_gate_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // A load wins over a tick in the same cycle; ticks only count afterwards.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // A nonzero load always arms the wait.
    assert_load_arms_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && (load_val_i != '0)) |=> !expired_o);

    // Without a tick the remaining wait cannot shrink.
    assert_no_tick_no_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i && !expired_o) |=> !expired_o);

endmodule

// File: rtl/pwr_gate_memctl.sv
module pwr_gate_memctl #(
    parameter int NUM_BANKS   = 2,
    parameter int BANK_WIDTH  = 32,
    parameter int SLICE_WIDTH = 2,
    parameter int AUX_BITS    = 8,
    parameter int IDX_W       = 6
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            init_on_i,
    input  logic                            go_i,
    input  logic                            down_i,
    input  logic [IDX_W-1:0]                idx_i,
    output logic [NUM_BANKS*BANK_WIDTH-1:0] bank_pd_o,
    output logic [AUX_BITS-1:0]             aux_pd_o
);

    localparam int SLICES = NUM_BANKS * BANK_WIDTH / SLICE_WIDTH;

    // Step index k < SLICES addresses slice k; banks are contiguous so the
    // third bank naturally follows the second.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        logic [SLICE_WIDTH-1:0] pd_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pd_q <= {SLICE_WIDTH{~init_on_i}};
            end else if (go_i && (idx_i == IDX_W'(s))) begin
                pd_q <= {SLICE_WIDTH{down_i}};
            end
        end
        assign bank_pd_o[s*SLICE_WIDTH +: SLICE_WIDTH] = pd_q;
    end

    // The single-bit group follows all bank slices.
    for (genvar a = 0; a < AUX_BITS; a++) begin : g_aux
        logic pd_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                pd_q <= ~init_on_i;
            end else if (go_i && (idx_i == IDX_W'(SLICES + a))) begin
                pd_q <= down_i;
            end
        end
        assign aux_pd_o[a] = pd_q;
    end

    logic seen_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    assert_step_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
        $countones({bank_pd_o, aux_pd_o} ^ $past({bank_pd_o, aux_pd_o})) <= SLICE_WIDTH);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pwr_gate_pkg::*;
#(
    parameter int NUM_BANKS    = 2,
    parameter int GUARD_TICKS  = 20,
    parameter int STEP_TICKS   = 5,
    parameter int SWITCH_TICKS = 20000
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tick_i,
    input  logic                    init_on_i,
    input  logic                    req_i,
    input  logic                    req_on_i,
    output logic                    ack_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    status_off_o,
    output logic                    iso_o,
    output logic                    sw_off_o,
    output logic                    dom_rst_o,
    output logic                    clk_en_a_o,
    output logic                    clk_en_b_o,
    output logic [NUM_BANKS*32-1:0] mem_pd_o,
    output logic [7:0]              aux_pd_o
);

    localparam int BANK_WIDTH  = 32;
    localparam int SLICE_WIDTH = 2;
    localparam int AUX_BITS    = 8;
    localparam int SLICES      = NUM_BANKS * BANK_WIDTH / SLICE_WIDTH;
    localparam int TOTAL_STEPS = SLICES + AUX_BITS;
    localparam int IDX_W       = $clog2(TOTAL_STEPS);
    localparam int MAX_WAIT    = max2(max2(GUARD_TICKS, STEP_TICKS), SWITCH_TICKS);
    localparam int CNT_W       = $clog2(MAX_WAIT + 1);
    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(TOTAL_STEPS - 1);

    seq_state_e       st_q, st_d;
    logic [IDX_W-1:0] step_q, step_d;
    logic             iso_q, iso_d, sw_q, sw_d, dr_q, dr_d;
    logic             ca_q, ca_d, cb_q, cb_d, ack_q, ack_d, done_q, done_d;
    logic             ld, expired, mgo, mdown;
    logic [CNT_W-1:0] ld_val;
    logic [IDX_W-1:0] midx;
    logic             dn_dir;

    assign dn_dir = (st_q == ST_DN_ISO) || (st_q == ST_DN_MEM);

    // Next state and per-step actions.
    always_comb begin
        st_d   = st_q;
        step_d = step_q;
        iso_d  = iso_q;
        sw_d   = sw_q;
        dr_d   = dr_q;
        ca_d   = ca_q;
        cb_d   = cb_q;
        ack_d  = 1'b0;
        done_d = 1'b0;
        ld     = 1'b0;
        ld_val = '0;
        mgo    = 1'b0;
        mdown  = dn_dir;
        midx   = step_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_i) begin
                    ack_d = 1'b1;
                    if (req_on_i && sw_q) begin
                        sw_d   = 1'b0;
                        ld     = 1'b1;
                        ld_val = CNT_W'(GUARD_TICKS);
                        st_d   = ST_UP_SWITCH;
                    end else if (!req_on_i && !sw_q) begin
                        iso_d  = 1'b1;
                        ld     = 1'b1;
                        ld_val = CNT_W'(GUARD_TICKS);
                        st_d   = ST_DN_ISO;
                    end
                end
            end
            ST_DN_ISO, ST_UP_SWITCH: begin
                if (expired) begin
                    mgo    = 1'b1;
                    midx   = '0;
                    step_d = '0;
                    ld     = 1'b1;
                    ld_val = CNT_W'(STEP_TICKS);
                    st_d   = dn_dir ? ST_DN_MEM : ST_UP_MEM;
                end
            end
            ST_DN_MEM, ST_UP_MEM: begin
                if (expired) begin
                    ld = 1'b1;
                    if (step_q == LAST_STEP) begin
                        ld_val = CNT_W'(GUARD_TICKS);
                        st_d   = dn_dir ? ST_DN_SETTLE : ST_UP_SETTLE;
                    end else begin
                        mgo    = 1'b1;
                        midx   = step_q + 1'b1;
                        step_d = step_q + 1'b1;
                        ld_val = CNT_W'(STEP_TICKS);
                    end
                end
            end
            ST_DN_SETTLE: begin
                if (expired) begin
                    sw_d   = 1'b1;
                    ld     = 1'b1;
                    ld_val = CNT_W'(SWITCH_TICKS);
                    st_d   = ST_DN_SWITCH;
                end
            end
            ST_DN_SWITCH: begin
                if (expired) begin
                    ca_d = 1'b0;
                    st_d = ST_DN_CLKB;
                end
            end
            ST_DN_CLKB: begin
                cb_d   = 1'b0;
                done_d = 1'b1;
                st_d   = ST_IDLE;
            end
            ST_UP_SETTLE: begin
                if (expired) begin
                    dr_d = 1'b1;
                    st_d = ST_UP_ISO;
                end
            end
            ST_UP_ISO: begin
                iso_d = 1'b0;
                st_d  = ST_UP_RST;
            end
            ST_UP_RST: begin
                dr_d = 1'b0;
                st_d = ST_UP_CLKA;
            end
            ST_UP_CLKA: begin
                ca_d = 1'b1;
                st_d = ST_UP_CLKB;
            end
            ST_UP_CLKB: begin
                cb_d   = 1'b1;
                done_d = 1'b1;
                st_d   = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
        end else begin
            st_q   <= st_d;
            step_q <= step_d;
        end
    end

    // Output register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            iso_q  <= ~init_on_i;
            sw_q   <= ~init_on_i;
            dr_q   <= 1'b0;
            ca_q   <= init_on_i;
            cb_q   <= init_on_i;
            ack_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            iso_q  <= iso_d;
            sw_q   <= sw_d;
            dr_q   <= dr_d;
            ca_q   <= ca_d;
            cb_q   <= cb_d;
            ack_q  <= ack_d;
            done_q <= done_d;
        end
    end

    pwr_gate_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (ld),
        .load_val_i (ld_val),
        .expired_o  (expired)
    );

    pwr_gate_memctl #(
        .NUM_BANKS   (NUM_BANKS),
        .BANK_WIDTH  (BANK_WIDTH),
        .SLICE_WIDTH (SLICE_WIDTH),
        .AUX_BITS    (AUX_BITS),
        .IDX_W       (IDX_W)
    ) u_memctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .init_on_i (init_on_i),
        .go_i      (mgo),
        .down_i    (mdown),
        .idx_i     (midx),
        .bank_pd_o (mem_pd_o),
        .aux_pd_o  (aux_pd_o)
    );

    assign ack_o        = ack_q;
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = done_q;
    assign status_off_o = sw_q;
    assign iso_o        = iso_q;
    assign sw_off_o     = sw_q;
    assign dom_rst_o    = dr_q;
    assign clk_en_a_o   = ca_q;
    assign clk_en_b_o   = cb_q;

    logic past_ok_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) past_ok_q <= 1'b0;
        else         past_ok_q <= 1'b1;
    end

    assert_iso_covers_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_q |-> iso_q);

    assert_clka_rise_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok_q)
        $rose(ca_q) |-> (!iso_q && !dr_q));

    assert_clkb_after_clka_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok_q)
        $rose(cb_q) |-> ($past(ca_q) && !iso_q && !dr_q));

    assert_no_ack_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != ST_IDLE) |=> !ack_q);

    assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |=> !done_q);

    assert_done_ends_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |-> (st_q == ST_IDLE));

endmodule

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;

    localparam int NB     = 3;
    localparam int GUARD  = 20;
    localparam int STEP   = 5;
    localparam int SWITCH = 120;
    localparam int PAIRS  = NB * 16;
    localparam int TOTAL  = PAIRS + 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, tick = 1'b0, init_on = 1'b0, req = 1'b0, req_on = 1'b0;
    logic ack_o, busy_o, done_o, status_off_o, iso_o, sw_off_o, dom_rst_o;
    logic clk_en_a_o, clk_en_b_o;
    logic [NB*32-1:0] mem_pd_o;
    logic [7:0] aux_pd_o;

    pwr_gate_seq #(
        .NUM_BANKS (NB), .GUARD_TICKS (GUARD), .STEP_TICKS (STEP), .SWITCH_TICKS (SWITCH)
    ) u_pwr_gate_seq (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .init_on_i (init_on),
        .req_i (req), .req_on_i (req_on), .ack_o (ack_o), .busy_o (busy_o),
        .done_o (done_o), .status_off_o (status_off_o), .iso_o (iso_o),
        .sw_off_o (sw_off_o), .dom_rst_o (dom_rst_o), .clk_en_a_o (clk_en_a_o),
        .clk_en_b_o (clk_en_b_o), .mem_pd_o (mem_pd_o), .aux_pd_o (aux_pd_o)
    );

    int checks = 0, fails = 0, tick_total = 0, acks = 0, tdiv = 0;
    logic [127:0] last_snap;
    int last_ticks;
    logic e_iso, e_sw, e_rst, e_ca, e_cb;
    logic [NB*32-1:0] e_mem;
    logic [7:0] e_aux;

    // One-cycle tick every third clock, changed away from the active edge.
    always @(negedge clk) begin
        if (tdiv == 2) begin tick = 1'b1; tdiv = 0; end
        else begin tick = 1'b0; tdiv = tdiv + 1; end
    end
    always @(posedge clk) if (tick) tick_total = tick_total + 1;
    always @(posedge clk) if (ack_o) acks = acks + 1;

    function automatic logic [127:0] dut_snap();
        return 128'({iso_o, sw_off_o, dom_rst_o, clk_en_a_o, clk_en_b_o, aux_pd_o, mem_pd_o});
    endfunction
    function automatic logic [127:0] exp_snap();
        return 128'({e_iso, e_sw, e_rst, e_ca, e_cb, e_aux, e_mem});
    endfunction

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_event(int min_gap, string tag);
        int n = 0;
        int gap;
        while (dut_snap() == last_snap && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(dut_snap() == exp_snap(), tag, dut_snap(), exp_snap());
        gap = tick_total - last_ticks;
        if (min_gap >= 0)
            check(gap >= min_gap && gap <= min_gap + 1, {"R11 tick spacing before ", tag},
                  128'(gap), 128'(min_gap));
        check(status_off_o == e_sw, "R7 status", 128'(status_off_o), 128'(e_sw));
        check(!(sw_off_o && !iso_o), "R5 isolation covers switch-off", 128'(iso_o), 128'(1));
        last_snap  = dut_snap();
        last_ticks = tick_total;
    endtask

    task automatic request(bit on);
        int n = 0;
        @(negedge clk);
        req = 1'b1;
        req_on = on;
        while (!ack_o && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(ack_o == 1'b1, "R8 request acknowledged in idle", 128'(ack_o), 128'(1));
        req = 1'b0;
    endtask

    task automatic model_step(int k, bit v);
        if (k < PAIRS) e_mem[2*k +: 2] = {2{v}};
        else           e_aux[k - PAIRS] = v;
    endtask

    function automatic string step_tag(int k);
        if (k >= PAIRS) return "R3 single-bit group step";
        if (k >= 32)    return "R12 third bank step";
        return "R3 bank pair step";
    endfunction

    task automatic finish_checks();
        check(done_o == 1'b1, "R10 done on final step", 128'(done_o), 128'(1));
        check(busy_o == 1'b0, "R10 busy low at final step", 128'(busy_o), 128'(0));
        @(negedge clk);
        check(done_o == 1'b0, "R10 done lasts one cycle", 128'(done_o), 128'(0));
    endtask

    task automatic run_off();
        e_iso = 1'b1;
        expect_event(-1, "R2 isolation first");
        for (int k = 0; k < TOTAL; k++) begin
            model_step(k, 1'b1);
            expect_event((k == 0) ? GUARD : STEP, step_tag(k));
            check(busy_o == 1'b1, "R10 busy during sequence", 128'(busy_o), 128'(1));
        end
        e_sw = 1'b1;
        expect_event(STEP + GUARD, "R2 switch off after settle");
        e_ca = 1'b0;
        expect_event(SWITCH, "R2 first clock off after long wait");
        e_cb = 1'b0;
        expect_event(0, "R2 second clock off");
        finish_checks();
    endtask

    task automatic run_on();
        e_sw = 1'b0;
        expect_event(-1, "R4 switch on first");
        for (int k = 0; k < TOTAL; k++) begin
            model_step(k, 1'b0);
            expect_event((k == 0) ? GUARD : STEP, step_tag(k));
            check(busy_o == 1'b1, "R10 busy during sequence", 128'(busy_o), 128'(1));
        end
        e_rst = 1'b1;
        expect_event(STEP + GUARD, "R4 reset asserted after settle");
        e_iso = 1'b0;
        expect_event(0, "R4 isolation released");
        e_rst = 1'b0;
        expect_event(0, "R4 reset released");
        e_ca = 1'b1;
        expect_event(0, "R6 first clock on");
        check(!iso_o && !dom_rst_o, "R6 clock rises with isolation and reset low",
              128'({iso_o, dom_rst_o}), 128'(0));
        e_cb = 1'b1;
        expect_event(0, "R6 second clock after first");
        finish_checks();
    endtask

    task automatic do_reset(bit on);
        rst_n = 1'b0;
        init_on = on;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        e_iso = ~on; e_sw = ~on; e_rst = 1'b0; e_ca = on; e_cb = on;
        e_mem = on ? '0 : '1;
        e_aux = on ? '0 : '1;
        check(dut_snap() == exp_snap(), "R1 reset state", dut_snap(), exp_snap());
        check(busy_o == 1'b0 && done_o == 1'b0 && ack_o == 1'b0, "R1 idle after reset",
              128'({busy_o, done_o, ack_o}), 128'(0));
        check(status_off_o == ~on, "R7 status after reset", 128'(status_off_o), 128'(~on));
        last_snap  = dut_snap();
        last_ticks = tick_total;
    endtask

    task automatic redundant_request(bit on);
        int base = acks;
        bit moved = 1'b0;
        request(on);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (busy_o || done_o) moved = 1'b1;
        end
        check(!moved, "R9 no sequence for redundant request", 128'(moved), 128'(0));
        check(dut_snap() == last_snap, "R9 outputs unchanged", dut_snap(), last_snap);
        check(acks == base + 1, "R9 single acknowledge", 128'(acks), 128'(base + 1));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int base;
        do_reset(1'b0);
        redundant_request(1'b0);          // shutdown while already off
        request(1'b1);
        run_on();
        redundant_request(1'b1);
        base = acks;
        request(1'b0);
        fork
            run_off();
            begin                          // R8: requests while busy are ignored
                repeat (300) @(negedge clk);
                req = 1'b1; req_on = 1'b1;
                repeat (4) @(negedge clk);
                req_on = 1'b0;
                repeat (4) @(negedge clk);
                req = 1'b0;
            end
        join
        check(acks == base + 1, "R8 no acknowledge while busy", 128'(acks), 128'(base + 1));
        do_reset(1'b1);
        request(1'b0);
        run_off();
        request(1'b1);
        run_on();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule